// File: doc/BRIEF.md
# Four-Channel Phase-Accumulator Clock Enable Generator

This block derives four auxiliary clock enables from a single fast divisor clock. Each channel holds a 14-bit increment register and a 14-bit accumulator that advances by that increment on every divisor clock cycle and wraps modulo 2^14. The top bit of the accumulator is the channel's output, so the output rate is increment × f_div / 2^14. For example, an increment of 696 with a 266 MHz divisor clock gives roughly 11.29 MHz, which is 256 times a 44.1 kHz sample rate. The output is clean only while the target rate stays below about a tenth of f_div.

The four channels feed the audio master clock, the video clock, an external clock pin and the UART clock. Software loads each increment through a one-cycle write strobe with a channel select.

After reset, a settling counter clocked by the oscillator input counts 2^WAIT_W rising edges. The default of 18 gives about 16.4 ms at 16 MHz. The counter then raises a sticky flag. A two-flop synchronizer carries that flag into the divisor clock domain, and until it arrives every accumulator is frozen and every output is low.

Top module: `multi_dco_clkgen`

## Requirements
- R1: While `rst_n` is low, every output is low. After reset all increments read as zero, so an output stays low until its channel is written again.
- R2: After reset is released, all outputs stay low and all accumulators stay frozen until 2^WAIT_W rising edges of `osc_in` have been counted. The enable then reaches the channels after two divisor clock edges.
- R3: Once set, the settling flag and the channel enable stay set until the next reset, even if `osc_in` stops toggling.
- R4: While enabled, each accumulator adds its current increment on every `clk_div` rising edge, modulo 2^14. The channel output is accumulator bit 13.
- R5: A write (`wr_en` high at a `clk_div` edge) loads `wr_data` into the selected channel's increment register. The new increment is first added at the following edge, and the write does not clear the accumulator.
- R6: When a channel's increment is zero, its output is low and its accumulator holds its value.
- R7: `wr_sel` selects the channel: 0 audio, 1 video, 2 external, 3 UART. A write changes no other channel.
- R8: With a constant increment P below 2^13, the output rises exactly P times in any window of 2^14 enabled cycles (P = 696 gives 696 rising edges).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_div | input | 1 | Fast divisor clock for all accumulators |
| rst_n | input | 1 | Asynchronous active-low reset for both domains |
| osc_in | input | 1 | Oscillator input clocking the settling counter |
| wr_en | input | 1 | Increment write strobe, sampled on `clk_div` |
| wr_sel | input | CH_W (2) | Channel index of the write |
| wr_data | input | PHASE_W (14) | Increment value to load |
| clk_en_o | output | NUM_CH (4) | Per-channel generated clock or enable, bit 0 audio to bit 3 UART |

## Verification
The properties assume three things about the inputs:
- `wr_sel` always names an existing channel.
- Reset is driven asynchronously, and the divisor and oscillator domains are treated as unrelated.
- `osc_in` keeps toggling at least until the settling flag is set.

The stimulus changes every input on the falling edge of `clk_div`. It releases reset at a falling edge that never coincides with an oscillator rising edge. It stops the oscillator only after the flag has been set, and the one exception is a deliberate test that its stopping has no effect. The increment values driven for the edge-count check stay below 2^13, so the top bit of the accumulator toggles exactly once per wrap.

// File: rtl/clkgen_pkg.sv
package clkgen_pkg;

    localparam int unsigned DFLT_NUM_CH  = 4;
    localparam int unsigned DFLT_PHASE_W = 14;
    localparam int unsigned DFLT_WAIT_W  = 18;

    // channel index as decoded from wr_sel
    typedef enum logic [1:0] {
        CH_AUDIO = 2'd0,
        CH_VIDEO = 2'd1,
        CH_EXT   = 2'd2,
        CH_UART  = 2'd3
    } clk_ch_e;

endpackage

// File: rtl/settle_wait.sv
module settle_wait #(
    parameter int unsigned WAIT_W = clkgen_pkg::DFLT_WAIT_W
) (
    input  logic osc_clk,
    input  logic rst_n,
    output logic ready_o
);

    typedef struct packed {
        logic [WAIT_W-1:0] cnt;
        logic              done;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (!st_q.done) begin
            st_d.cnt = st_q.cnt + 1'b1;
            if (&st_q.cnt) begin
                st_d.done = 1'b1;
            end
        end
    end

    always_ff @(posedge osc_clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign ready_o = st_q.done;

endmodule

// File: rtl/sync2.sv
module sync2 (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout
);

    typedef struct packed {
        logic s1;
        logic s2;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d.s1 = din;
        st_d.s2 = st_q.s1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign dout = st_q.s2;

endmodule

// File: rtl/dco_channel.sv
module dco_channel #(
    parameter int unsigned PHASE_W = clkgen_pkg::DFLT_PHASE_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               run,
    input  logic               load,
    input  logic [PHASE_W-1:0] load_val,
    output logic               clk_en_o,
    output logic [PHASE_W-1:0] acc_o,
    output logic [PHASE_W-1:0] phase_o
);

    typedef struct packed {
        logic [PHASE_W-1:0] acc;
        logic [PHASE_W-1:0] phase;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (load) begin
            st_d.phase = load_val;
        end
        if (run) begin
            st_d.acc = st_q.acc + st_q.phase;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign clk_en_o = st_q.acc[PHASE_W-1] & (|st_q.phase);
    assign acc_o    = st_q.acc;
    assign phase_o  = st_q.phase;

endmodule

// File: rtl/multi_dco_clkgen.sv
module multi_dco_clkgen #(
    parameter int unsigned NUM_CH  = clkgen_pkg::DFLT_NUM_CH,
    parameter int unsigned PHASE_W = clkgen_pkg::DFLT_PHASE_W,
    parameter int unsigned WAIT_W  = clkgen_pkg::DFLT_WAIT_W,
    parameter int unsigned CH_W    = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
    input  logic               clk_div,
    input  logic               rst_n,
    input  logic               osc_in,
    input  logic               wr_en,
    input  logic [CH_W-1:0]    wr_sel,
    input  logic [PHASE_W-1:0] wr_data,
    output logic [NUM_CH-1:0]  clk_en_o
);

    localparam int unsigned FLAT_W = NUM_CH * PHASE_W;

    logic              settled_osc;
    logic              run_div;
    logic [FLAT_W-1:0] acc_all;
    logic [FLAT_W-1:0] phase_all;

    settle_wait #(
        .WAIT_W(WAIT_W)
    ) i_settle (
        .osc_clk (osc_in),
        .rst_n   (rst_n),
        .ready_o (settled_osc)
    );

    sync2 i_sync (
        .clk   (clk_div),
        .rst_n (rst_n),
        .din   (settled_osc),
        .dout  (run_div)
    );

    for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
        logic ld;
        assign ld = wr_en && (wr_sel == CH_W'(g));

        dco_channel #(
            .PHASE_W(PHASE_W)
        ) i_ch (
            .clk      (clk_div),
            .rst_n    (rst_n),
            .run      (run_div),
            .load     (ld),
            .load_val (wr_data),
            .clk_en_o (clk_en_o[g]),
            .acc_o    (acc_all[g*PHASE_W +: PHASE_W]),
            .phase_o  (phase_all[g*PHASE_W +: PHASE_W])
        );
    end

endmodule

// File: rtl/clkgen_chk.sv
module clkgen_chk #(
    parameter int unsigned NUM_CH  = 4,
    parameter int unsigned PHASE_W = 14,
    parameter int unsigned CH_W    = 2
) (
    input logic                      clk_div,
    input logic                      rst_n,
    input logic                      osc_in,
    input logic                      settled_osc,
    input logic                      run_div,
    input logic                      wr_en,
    input logic [CH_W-1:0]           wr_sel,
    input logic [PHASE_W-1:0]        wr_data,
    input logic [NUM_CH*PHASE_W-1:0] acc_all,
    input logic [NUM_CH*PHASE_W-1:0] phase_all,
    input logic [NUM_CH-1:0]         clk_en_o
);

    // R2
    gated_off_chk: assert property (@(posedge clk_div) disable iff (!rst_n)
        !run_div |-> (clk_en_o == '0));

    // R2
    frozen_acc_chk: assert property (@(posedge clk_div) disable iff (!rst_n)
        !run_div |=> $stable(acc_all));

    // R3
    run_sticky_chk: assert property (@(posedge clk_div) disable iff (!rst_n)
        run_div |=> run_div);

    // R3
    settle_sticky_chk: assert property (@(posedge osc_in) disable iff (!rst_n)
        settled_osc |=> settled_osc);

    for (genvar g = 0; g < NUM_CH; g++) begin : g_chk
        // R5
        phase_load_chk: assert property (@(posedge clk_div) disable iff (!rst_n)
            (wr_en && wr_sel == CH_W'(g)) |=>
                (phase_all[g*PHASE_W +: PHASE_W] == $past(wr_data)));

        // R7
        phase_keep_chk: assert property (@(posedge clk_div) disable iff (!rst_n)
            !(wr_en && wr_sel == CH_W'(g)) |=> $stable(phase_all[g*PHASE_W +: PHASE_W]));

        // R6
        zero_phase_hold_chk: assert property (@(posedge clk_div) disable iff (!rst_n)
            (phase_all[g*PHASE_W +: PHASE_W] == '0) |=> $stable(acc_all[g*PHASE_W +: PHASE_W]));
    end

endmodule

bind multi_dco_clkgen clkgen_chk #(
    .NUM_CH  (NUM_CH),
    .PHASE_W (PHASE_W),
    .CH_W    (CH_W)
) i_clkgen_chk (
    .clk_div     (clk_div),
    .rst_n       (rst_n),
    .osc_in      (osc_in),
    .settled_osc (settled_osc),
    .run_div     (run_div),
    .wr_en       (wr_en),
    .wr_sel      (wr_sel),
    .wr_data     (wr_data),
    .acc_all     (acc_all),
    .phase_all   (phase_all),
    .clk_en_o    (clk_en_o)
);

// File: tb/test_multi_dco_clkgen.sv
module test_multi_dco_clkgen;
    import clkgen_pkg::*;

    localparam int NCH = 4;
    localparam int PW  = 14;
    localparam int WW  = 4;
    localparam int CW  = 2;
    localparam int SETTLE_EDGES = 1 << WW;

    typedef struct packed {
        logic [1:0]  ch;
        logic [13:0] ph;
        logic [15:0] cyc;
    } vec_t;

    localparam int NVEC = 8;
    localparam vec_t VECS [NVEC] = '{
        '{2'd0, 14'h2000, 16'd40},
        '{2'd1, 14'h1000, 16'd40},
        '{2'd2, 14'h0400, 16'd70},
        '{2'd3, 14'h0001, 16'd20},
        '{2'd0, 14'h0155, 16'd50},
        '{2'd1, 14'h0000, 16'd30},
        '{2'd2, 14'h1FFF, 16'd40},
        '{2'd3, 14'h0800, 16'd40}
    };

    logic          clk_div = 1'b0;
    logic          rst_n   = 1'b0;
    logic          osc_in  = 1'b0;
    logic          osc_run = 1'b1;
    logic          wr_en   = 1'b0;
    logic [CW-1:0] wr_sel  = '0;
    logic [PW-1:0] wr_data = '0;
    logic [NCH-1:0] clk_en_o;

    int checks = 0;
    int fails  = 0;
    int osc_edges;
    int mism;
    logic [PW-1:0] acc_m [NCH];
    logic [PW-1:0] ph_m  [NCH];

    always #10 clk_div = ~clk_div;
    always #30 if (osc_run) osc_in = ~osc_in;

    always @(posedge osc_in or negedge rst_n) begin
        if (!rst_n) osc_edges <= 0;
        else        osc_edges <= osc_edges + 1;
    end

    multi_dco_clkgen #(
        .NUM_CH  (NCH),
        .PHASE_W (PW),
        .WAIT_W  (WW)
    ) i_multi_dco_clkgen (
        .clk_div  (clk_div),
        .rst_n    (rst_n),
        .osc_in   (osc_in),
        .wr_en    (wr_en),
        .wr_sel   (wr_sel),
        .wr_data  (wr_data),
        .clk_en_o (clk_en_o)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [NCH-1:0] model_out();
        logic [NCH-1:0] o;
        for (int c = 0; c < NCH; c++) o[c] = (ph_m[c] != '0) & acc_m[c][PW-1];
        return o;
    endfunction

    task automatic model_clear();
        for (int c = 0; c < NCH; c++) begin
            acc_m[c] = '0;
            ph_m[c]  = '0;
        end
    endtask

    // one divisor cycle; called and returns at a falling edge
    task automatic step();
        @(posedge clk_div);
        for (int c = 0; c < NCH; c++) acc_m[c] = acc_m[c] + ph_m[c];
        if (wr_en) ph_m[wr_sel] = wr_data;
        @(negedge clk_div);
        if (clk_en_o !== model_out()) mism++;
    endtask

    task automatic wr(input int ch, input logic [PW-1:0] val);
        wr_en = 1'b1; wr_sel = CW'(ch); wr_data = val;
        step();
        wr_en = 1'b0;
    endtask

    // outputs must stay low until the settling count completes
    task automatic wait_settle_low();
        int bad = 0;
        while (osc_edges < SETTLE_EDGES) begin
            step();
            if (clk_en_o !== '0) bad++;
        end
        repeat (4) step();
        chk("R2 outputs low before settle", bad, 0);
    endtask

    initial begin
        model_clear();
        mism = 0;
        @(negedge clk_div);
        repeat (3) @(negedge clk_div);
        chk("R1 outputs during reset", 32'(clk_en_o), 0);
        rst_n = 1'b1;

        // increments written before settling must not move the outputs
        wr(CH_AUDIO, 14'h2000);
        wr(CH_VIDEO, 14'h1000);
        begin
            int bad = 0;
            while (osc_edges < SETTLE_EDGES - 3) begin
                step();
                if (clk_en_o !== '0) bad++;
            end
            chk("R2 frozen with nonzero increment", bad, 0);
        end
        wr(CH_AUDIO, 14'h0000);
        wr(CH_VIDEO, 14'h0000);
        wait_settle_low();
        model_clear();

        // vector table
        for (int i = 0; i < NVEC; i++) begin
            mism = 0;
            wr(int'(VECS[i].ch), VECS[i].ph);
            for (int k = 0; k < int'(VECS[i].cyc); k++) step();
            chk($sformatf("R4 R5 R6 R7 vec%0d mismatches", i), mism, 0);
        end

        // zero increment holds low
        begin
            int hi = 0;
            for (int k = 0; k < 30; k++) begin
                step();
                if (clk_en_o[CH_VIDEO] !== 1'b0) hi++;
            end
            chk("R6 zero increment output low", hi, 0);
        end

        // exact edge count over 2^14 cycles
        begin
            int rises = 0;
            logic prev;
            mism = 0;
            wr(CH_AUDIO, 14'd696);
            prev = clk_en_o[CH_AUDIO];
            for (int k = 0; k < (1 << PW); k++) begin
                step();
                if (!prev && clk_en_o[CH_AUDIO]) rises++;
                prev = clk_en_o[CH_AUDIO];
            end
            chk("R8 rising edges for 696", rises, 696);
            chk("R4 model during long run", mism, 0);
        end

        // enable stays with oscillator stopped
        begin
            int tog = 0;
            logic prev;
            mism = 0;
            osc_run = 1'b0;
            prev = clk_en_o[CH_UART];
            for (int k = 0; k < 80; k++) begin
                step();
                if (prev != clk_en_o[CH_UART]) tog++;
                prev = clk_en_o[CH_UART];
            end
            chk("R3 run holds without oscillator", mism, 0);
            chk("R3 uart keeps toggling", 32'(tog > 0), 1);
            osc_run = 1'b1;
        end

        // reset in mid run
        wr(CH_EXT, 14'h2000);
        rst_n = 1'b0;
        @(negedge clk_div);
        chk("R1 outputs low in reset", 32'(clk_en_o), 0);
        model_clear();
        rst_n = 1'b1;
        wait_settle_low();
        begin
            int hi = 0;
            for (int k = 0; k < 40; k++) begin
                step();
                if (clk_en_o !== '0) hi++;
            end
            chk("R1 increments cleared by reset", hi, 0);
        end
        mism = 0;
        wr(CH_UART, 14'h2000);
        for (int k = 0; k < 12; k++) step();
        chk("R2 R7 running after second settle", mism, 0);

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        #(20 * 100000);
        checks++;
        fails++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule